// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers reset requests from several places and chooses one of three reset flows: power-on, hard or soft. It drives three separate active-low reset outputs: one for clock logic, one for error-capture logic and one for general device logic. It also raises a reset-exception request to the processor core. An open-drain hard-reset pad is modelled as a sense input plus a drive-low enable, so the board wire is the AND of every driver.

Watchdog expiry, bus-monitor timeout and core checkstop arrive as single-cycle events. Each is gated by its own bit in a mode register before it can start a hard flow. A test-access soft-reset pulse starts the soft flow. Software starts a hard flow by writing a key value to a command register. A sticky status register records the causes of the most recent flow and is cleared by writing ones to it. Power-on reset is the asynchronous reset of the whole controller and always takes over, even in the middle of another flow.

Top module: `rst_orchestrator`

## Requirements
- R1: While `por_n_i` is low, all three reset outputs are low, the pad is not driven and `core_soft_req_o` is low; this holds at once, even in the middle of a flow. After `por_n_i` rises, all three reset outputs go high on the second rising clock edge. After power-on, status reads 0x01 (bit 0 = power-on cause only) and mode reads 0x00.
- R2: A hard flow holds `dev_rst_n_o` low for exactly ASSERT_CYC+SETTLE_CYC (80) consecutive cycles. `clk_rst_n_o` and `err_rst_n_o` stay high throughout.
- R3: During a hard flow the pad is driven low for exactly ASSERT_CYC (64) cycles. It is then released for SETTLE_CYC (16) cycles before the device reset is released and detection is armed again.
- R4: A low level on the pad while the controller is idle starts a hard flow after a two-flop synchronizer, and sets status bit 1. The low level caused by the controller's own drive never starts a second flow.
- R5: A `wdog_evt_i` pulse starts a hard flow and sets status bit 3 only when mode bit 0 is 1; otherwise it has no effect.
- R6: A `busmon_evt_i` pulse starts a hard flow and sets status bit 4 only when mode bit 1 is 1; otherwise it has no effect.
- R7: A `chkstop_evt_i` pulse starts a hard flow and sets status bit 5 only when mode bit 2 is 1; otherwise it has no effect.
- R8: Writing KEY (0xA5) to address 1 starts a hard flow and sets status bit 2. Any other value written there has no effect.
- R9: A `jtag_soft_i` pulse raises `core_soft_req_o` for exactly SOFT_CYC (8) cycles, leaves all three reset outputs high and sets status bit 6.
- R10: Requests that arrive while a flow is running are ignored. They do not lengthen the flow, start another flow or set status bits.
- R11: Status bits are sticky. All hard causes that are present in the starting cycle are recorded together. If a hard cause and a soft request arrive in the same cycle, the hard flow runs and the soft request is neither run nor recorded. Writing to address 2 clears exactly the bits written as 1.
- R12: Register map. Address 0 is mode, with bits [2:0] = {checkstop, bus-monitor, watchdog} enables. Address 1 is the command register, which reads 0. Address 2 is status, with bits [6:0]. Reads are combinational from `reg_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n_i | input | 1 | Asynchronous power-on request, active low |
| pad_in_i | input | 1 | Sensed level of the open-drain hard-reset pad |
| pad_drive_o | output | 1 | When 1, the pad is pulled low |
| wdog_evt_i | input | 1 | Watchdog expiry event, one cycle |
| busmon_evt_i | input | 1 | Bus-monitor timeout event, one cycle |
| chkstop_evt_i | input | 1 | Core checkstop event, one cycle |
| jtag_soft_i | input | 1 | Test-access soft-reset request, one cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| clk_rst_n_o | output | 1 | Clock-domain reset, active low |
| err_rst_n_o | output | 1 | Error-capture reset, active low |
| dev_rst_n_o | output | 1 | Device-logic reset, active low |
| core_soft_req_o | output | 1 | Reset-exception request to the core |

## Verification
The assertions assume that `por_n_i` is the only asynchronous input and that the event and register inputs are synchronous to `clk`, with events lasting one cycle. They also assume the pad wire reads low whenever the controller drives it. The bench changes every input on the falling clock edge. It models the pad as the AND of the controller's drive and an external pull-down, and gives each pulse exactly one cycle. Requests injected during a flow are timed to land in both the drive window and the settle window.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDRV,
        ST_HSET,
        ST_SOFT
    } seq_st_e;

    localparam int NCAUSE   = 7;
    localparam int MODE_W   = 3;
    localparam int C_POR    = 0;
    localparam int C_EXT    = 1;
    localparam int C_SW     = 2;
    localparam int C_WDOG   = 3;
    localparam int C_BUSMON = 4;
    localparam int C_CHKSTP = 5;
    localparam int C_JTAG   = 6;
    localparam int M_WDOG   = 0;
    localparam int M_BUSMON = 1;
    localparam int M_CHKSTP = 2;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
    import rstc_pkg::*;
#(
    parameter int ASSERT_CYC = 64,
    parameter int SETTLE_CYC = 16,
    parameter int SOFT_CYC   = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic start_hard_i,
    input  logic start_soft_i,
    output logic idle_o,
    output logic hard_o,
    output logic drive_o,
    output logic soft_o
);
    localparam int MAXC = (ASSERT_CYC > SETTLE_CYC)
                        ? ((ASSERT_CYC > SOFT_CYC) ? ASSERT_CYC : SOFT_CYC)
                        : ((SETTLE_CYC > SOFT_CYC) ? SETTLE_CYC : SOFT_CYC);
    localparam int CW = $clog2(MAXC) + 1;

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_hard_i) begin
                    s_d.st  = ST_HDRV;
                    s_d.cnt = CW'(ASSERT_CYC - 1);
                end else if (start_soft_i) begin
                    s_d.st  = ST_SOFT;
                    s_d.cnt = CW'(SOFT_CYC - 1);
                end
            end
            ST_HDRV: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = ST_HSET;
                    s_d.cnt = CW'(SETTLE_CYC - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_HSET, ST_SOFT: begin
                if (s_q.cnt == '0) s_d.st = ST_IDLE;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) s_q <= '{st: ST_IDLE, cnt: '0};
        else         s_q <= s_d;
    end

    assign idle_o  = (s_q.st == ST_IDLE);
    assign drive_o = (s_q.st == ST_HDRV);
    assign hard_o  = (s_q.st == ST_HDRV) || (s_q.st == ST_HSET);
    assign soft_o  = (s_q.st == ST_SOFT);
endmodule

// File: rtl/rstc_regs.sv
module rstc_regs
    import rstc_pkg::*;
#(
    parameter int          DW  = 8,
    parameter logic [DW-1:0] KEY = 8'hA5
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          por_ok_i,
    input  logic          seq_idle_i,
    input  logic          pad_low_i,
    input  logic          wdog_i,
    input  logic          busmon_i,
    input  logic          chkstop_i,
    input  logic          jtag_i,
    input  logic          we_i,
    input  logic [1:0]    addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          start_hard_o,
    output logic          start_soft_o
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [NCAUSE-1:0] stat;
    } regs_t;

    regs_t r_d, r_q;
    logic [NCAUSE-1:0] hard_vec, clr_vec, set_vec;
    logic go, wr_ok;

    always_comb begin
        r_d   = r_q;
        wr_ok = por_ok_i && we_i;
        go    = por_ok_i && seq_idle_i;

        hard_vec           = '0;
        hard_vec[C_EXT]    = pad_low_i;
        hard_vec[C_SW]     = wr_ok && (addr_i == 2'd1) && (wdata_i == KEY);
        hard_vec[C_WDOG]   = wdog_i    && r_q.mode[M_WDOG];
        hard_vec[C_BUSMON] = busmon_i  && r_q.mode[M_BUSMON];
        hard_vec[C_CHKSTP] = chkstop_i && r_q.mode[M_CHKSTP];

        start_hard_o = go && (|hard_vec);
        start_soft_o = go && jtag_i && !(|hard_vec);

        set_vec = '0;
        if (start_hard_o) set_vec = hard_vec;
        if (start_soft_o) set_vec[C_JTAG] = 1'b1;

        clr_vec = (wr_ok && addr_i == 2'd2) ? wdata_i[NCAUSE-1:0] : '0;
        r_d.stat = (r_q.stat & ~clr_vec) | set_vec;

        if (wr_ok && addr_i == 2'd0) r_d.mode = wdata_i[MODE_W-1:0];

        unique case (addr_i)
            2'd0:    rdata_o = DW'(r_q.mode);
            2'd2:    rdata_o = DW'(r_q.stat);
            default: rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) r_q <= '{mode: '0, stat: NCAUSE'(1) << C_POR};
        else         r_q <= r_d;
    end
endmodule

// File: rtl/rst_orchestrator.sv
module rst_orchestrator
    import rstc_pkg::*;
#(
    parameter int            ASSERT_CYC = 64,
    parameter int            SETTLE_CYC = 16,
    parameter int            SOFT_CYC   = 8,
    parameter int            DW         = 8,
    parameter logic [DW-1:0] KEY        = 8'hA5
) (
    input  logic          clk,
    input  logic          por_n_i,
    input  logic          pad_in_i,
    output logic          pad_drive_o,
    input  logic          wdog_evt_i,
    input  logic          busmon_evt_i,
    input  logic          chkstop_evt_i,
    input  logic          jtag_soft_i,
    input  logic          reg_we_i,
    input  logic [1:0]    reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          clk_rst_n_o,
    output logic          err_rst_n_o,
    output logic          dev_rst_n_o,
    output logic          core_soft_req_o
);
    logic por_ok, pad_s;
    logic seq_idle, seq_hard, seq_drive, seq_soft;
    logic go_hard, go_soft;

    rstc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_por_sync (
        .clk(clk), .arst_n(por_n_i), .d_i(1'b1), .q_o(por_ok)
    );

    rstc_sync #(.STAGES(2), .RST_VAL(1'b1)) u_pad_sync (
        .clk(clk), .arst_n(por_n_i), .d_i(pad_in_i), .q_o(pad_s)
    );

    rstc_regs #(.DW(DW), .KEY(KEY)) u_regs (
        .clk(clk), .arst_n(por_n_i), .por_ok_i(por_ok), .seq_idle_i(seq_idle),
        .pad_low_i(!pad_s), .wdog_i(wdog_evt_i), .busmon_i(busmon_evt_i),
        .chkstop_i(chkstop_evt_i), .jtag_i(jtag_soft_i), .we_i(reg_we_i),
        .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
        .start_hard_o(go_hard), .start_soft_o(go_soft)
    );

    rstc_seq #(.ASSERT_CYC(ASSERT_CYC), .SETTLE_CYC(SETTLE_CYC), .SOFT_CYC(SOFT_CYC)) u_seq (
        .clk(clk), .arst_n(por_n_i), .start_hard_i(go_hard), .start_soft_i(go_soft),
        .idle_o(seq_idle), .hard_o(seq_hard), .drive_o(seq_drive), .soft_o(seq_soft)
    );

    assign clk_rst_n_o     = por_ok;
    assign err_rst_n_o     = por_ok;
    assign dev_rst_n_o     = por_ok && !seq_hard;
    assign pad_drive_o     = seq_drive;
    assign core_soft_req_o = seq_soft;
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk #(
    parameter int ASSERT_CYC = 64,
    parameter int SETTLE_CYC = 16
) (
    input logic clk,
    input logic por_n_i,
    input logic pad_drive_o,
    input logic clk_rst_n_o,
    input logic err_rst_n_o,
    input logic dev_rst_n_o,
    input logic core_soft_req_o
);
    localparam int RW = $clog2(ASSERT_CYC + SETTLE_CYC) + 2;
    logic [RW-1:0] run_q, quiet_q;

    always_ff @(posedge clk or negedge por_n_i) begin
        if (!por_n_i) begin
            run_q   <= '0;
            quiet_q <= RW'(SETTLE_CYC);
        end else begin
            run_q   <= pad_drive_o ? run_q + 1'b1 : '0;
            quiet_q <= pad_drive_o ? '0
                     : (quiet_q < RW'(SETTLE_CYC)) ? quiet_q + 1'b1 : quiet_q;
        end
    end

    // R1
    clk_covers_all_chk: assert property (@(posedge clk) disable iff (!por_n_i)
        !clk_rst_n_o |-> (!err_rst_n_o && !dev_rst_n_o));

    // R2
    drive_in_reset_chk: assert property (@(posedge clk) disable iff (!por_n_i)
        pad_drive_o |-> (!dev_rst_n_o && clk_rst_n_o && err_rst_n_o));

    // R3
    drive_len_chk: assert property (@(posedge clk) disable iff (!por_n_i)
        pad_drive_o |-> (run_q < RW'(ASSERT_CYC)));

    // R3
    drive_full_chk: assert property (@(posedge clk) disable iff (!por_n_i)
        $fell(pad_drive_o) |-> (run_q == RW'(ASSERT_CYC)));

    // R3
    settle_chk: assert property (@(posedge clk) disable iff (!por_n_i)
        $rose(dev_rst_n_o) |-> (quiet_q >= RW'(SETTLE_CYC)));

    // R9
    soft_no_reset_chk: assert property (@(posedge clk) disable iff (!por_n_i)
        core_soft_req_o |-> (dev_rst_n_o && !pad_drive_o));
endmodule

bind rst_orchestrator rstc_chk #(.ASSERT_CYC(ASSERT_CYC), .SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk(clk), .por_n_i(por_n_i), .pad_drive_o(pad_drive_o),
    .clk_rst_n_o(clk_rst_n_o), .err_rst_n_o(err_rst_n_o),
    .dev_rst_n_o(dev_rst_n_o), .core_soft_req_o(core_soft_req_o)
);

// File: tb/tb_rst_orchestrator.sv
module tb_rst_orchestrator;
    localparam int HARD_T = 80;
    localparam int DRV_T  = 64;
    localparam int SOFT_T = 8;
    localparam int WIN    = 130;

    logic clk = 1'b0;
    logic por_n = 1'b1;
    logic ext_low = 1'b0;
    logic wd = 1'b0, bm = 1'b0, cs = 1'b0, js = 1'b0;
    logic we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0, rdata;
    logic pad_drive, clk_rst_n, err_rst_n, dev_rst_n, soft_req;
    logic pad_in;
    int total = 0, bad = 0;

    assign pad_in = !(ext_low || pad_drive);

    always #5 clk = ~clk;

    rst_orchestrator dut (
        .clk(clk), .por_n_i(por_n), .pad_in_i(pad_in), .pad_drive_o(pad_drive),
        .wdog_evt_i(wd), .busmon_evt_i(bm), .chkstop_evt_i(cs), .jtag_soft_i(js),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .clk_rst_n_o(clk_rst_n), .err_rst_n_o(err_rst_n), .dev_rst_n_o(dev_rst_n),
        .core_soft_req_o(soft_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = 8'd0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic pulse(input logic [3:0] m);
        {js, cs, bm, wd} = m;
        @(negedge clk);
        {js, cs, bm, wd} = 4'b0;
    endtask

    // Samples WIN cycles: device-reset low, pad drive, soft request, other-domain reset.
    task automatic probe(input int inj_at, input logic [3:0] inj, input int ext_hold,
                         output int rc, output int pc, output int sc, output int oc);
        rc = 0; pc = 0; sc = 0; oc = 0;
        for (int i = 0; i < WIN; i++) begin
            if (!dev_rst_n) rc++;
            if (pad_drive) pc++;
            if (soft_req) sc++;
            if (!clk_rst_n || !err_rst_n) oc++;
            if (i == ext_hold) ext_low = 1'b0;
            if (i == inj_at) {js, cs, bm, wd} = inj;
            else {js, cs, bm, wd} = 4'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, rc, pc, sc, oc;
        #1 por_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 held in power-on
        chk("R1 clk_rst held", int'(clk_rst_n), 0);
        chk("R1 err_rst held", int'(err_rst_n), 0);
        chk("R1 dev_rst held", int'(dev_rst_n), 0);
        chk("R1 pad idle", int'(pad_drive), 0);
        chk("R1 soft idle", int'(soft_req), 0);
        por_n = 1'b1;
        @(negedge clk);
        chk("R1 one edge after release", int'(clk_rst_n), 0);
        @(negedge clk);
        chk("R1 clk_rst released", int'(clk_rst_n), 1);
        chk("R1 err_rst released", int'(err_rst_n), 1);
        chk("R1 dev_rst released", int'(dev_rst_n), 1);
        rd(2'd2, v); chk("R1 status por only", v, 1);
        rd(2'd0, v); chk("R12 mode reset", v, 0);
        rd(2'd1, v); chk("R12 command reads zero", v, 0);
        @(negedge clk);
        wr(2'd2, 8'h7F);
        rd(2'd2, v); chk("R11 w1c all", v, 0);

        // R5 R6 R7: sweep all enable masks against each gated event
        for (int m = 0; m < 8; m++) begin
            wr(2'd0, 8'(m));
            rd(2'd0, v); chk("R12 mode readback", v, m);
            for (int s = 0; s < 3; s++) begin
                int en;
                string tg;
                en = (m >> s) & 1;
                tg = (s == 0) ? "R5" : (s == 1) ? "R6" : "R7";
                pulse(4'(1 << s));
                probe(-1, 4'b0, -1, rc, pc, sc, oc);
                chk({tg, " dev reset length"}, rc, en ? HARD_T : 0);
                chk({tg, " pad drive length"}, pc, en ? DRV_T : 0);
                chk("R2 other domains untouched", oc, 0);
                rd(2'd2, v); chk({tg, " status"}, v, en ? (1 << (3 + s)) : 0);
                wr(2'd2, 8'h7F);
            end
        end

        // R8 software command
        wr(2'd1, 8'h5A);
        probe(-1, 4'b0, -1, rc, pc, sc, oc);
        chk("R8 wrong key ignored", rc, 0);
        rd(2'd2, v); chk("R8 wrong key no status", v, 0);
        wr(2'd1, 8'hA5);
        probe(-1, 4'b0, -1, rc, pc, sc, oc);
        chk("R8 key dev reset", rc, HARD_T);
        chk("R3 key pad drive", pc, DRV_T);
        rd(2'd2, v); chk("R8 key status", v, 4);
        wr(2'd2, 8'h7F);

        // R9 soft flow
        pulse(4'b1000);
        probe(-1, 4'b0, -1, rc, pc, sc, oc);
        chk("R9 soft request length", sc, SOFT_T);
        chk("R9 no device reset", rc, 0);
        chk("R9 no other reset", oc, 0);
        rd(2'd2, v); chk("R9 status", v, 64);
        wr(2'd2, 8'h7F);

        // R4 external pad assertion
        ext_low = 1'b1;
        probe(-1, 4'b0, 4, rc, pc, sc, oc);
        chk("R4 ext dev reset", rc, HARD_T);
        chk("R4 ext pad drive", pc, DRV_T);
        rd(2'd2, v); chk("R4 ext status", v, 2);
        wr(2'd2, 8'h7F);

        // R10 requests during drive and settle windows ignored
        wr(2'd0, 8'h07);
        pulse(4'b0001);
        probe(10, 4'b1110, -1, rc, pc, sc, oc);
        chk("R10 drive-window inject length", rc, HARD_T);
        chk("R10 drive-window no soft", sc, 0);
        rd(2'd2, v); chk("R10 drive-window status", v, 8);
        wr(2'd2, 8'h7F);
        pulse(4'b0001);
        probe(70, 4'b1111, -1, rc, pc, sc, oc);
        chk("R10 settle-window inject length", rc, HARD_T);
        chk("R10 settle-window no soft", sc, 0);
        rd(2'd2, v); chk("R10 settle-window status", v, 8);
        wr(2'd2, 8'h7F);

        // R11 simultaneous causes, hard beats soft, sticky, partial clear
        pulse(4'b1011);
        probe(-1, 4'b0, -1, rc, pc, sc, oc);
        chk("R11 joint hard length", rc, HARD_T);
        chk("R11 soft dropped", sc, 0);
        rd(2'd2, v); chk("R11 joint status", v, 8'h18);
        pulse(4'b1000);
        probe(-1, 4'b0, -1, rc, pc, sc, oc);
        rd(2'd2, v); chk("R11 sticky accumulate", v, 8'h58);
        wr(2'd2, 8'h08);
        rd(2'd2, v); chk("R11 partial clear", v, 8'h50);

        // R1 power-on takes over mid-flow
        pulse(4'b0001);
        repeat (5) @(negedge clk);
        chk("R1 mid-flow pad driven before", int'(pad_drive), 1);
        por_n = 1'b0;
        #1;
        chk("R1 takeover pad released", int'(pad_drive), 0);
        chk("R1 takeover clk_rst", int'(clk_rst_n), 0);
        chk("R1 takeover err_rst", int'(err_rst_n), 0);
        @(negedge clk);
        por_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 takeover released", int'(dev_rst_n), 1);
        rd(2'd2, v); chk("R1 takeover status", v, 1);
        rd(2'd0, v); chk("R1 takeover mode cleared", v, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule